// File: doc/BRIEF.md
# Epoch-Tagged Fetch Redirect Controller

This block holds together a fetch stage and an execute stage that run apart from each other. The fetch side owns the program counter. Each cycle that it has room, it issues one instruction and steers the counter to the address the external next-address predictor supplies. Every issued instruction travels to execute through an internal in-order queue. It carries its own address, the address that was predicted to follow it, the instruction word and a one-bit generation tag.

The execute side owns a second one-bit generation register. An instruction whose tag does not match that register belongs to a path that was abandoned. It is removed when execute accepts it and has no effect. For a matching instruction, the branch resolution from outside (taken flag and target) gives the correct successor, which is compared with the prediction. On a mismatch, execute flips its own generation at once and posts a redirect (branch address, correct successor) into a redirect queue. When fetch next issues an instruction, it takes the redirect: it reloads the counter, flips its own generation and sends a one-cycle training pulse to the predictor.

The redirect queue is either a pass-through queue or a plain queue, chosen by parameter. With the pass-through queue, fetch can act in the same cycle as the mispredict. With the plain queue, fetch acts one cycle later at the earliest. The instruction queue is a valid/ready stream: `ex_valid` is the offer, `res_valid` is the accept, and fetch is throttled only by that queue's occupancy.

Top module: `fetch_redirect_unit`

## Requirements
- R1: While reset is asserted, `fetch_pc` equals the reset address (parameter, default 0), `ex_valid`, `ex_live`, `mispredict` and `upd_valid` are low, and both generation bits are equal.
- R2: Instructions reach the execute port in issue order, each with the `fetch_pc`, `pred_npc` and `imem_inst` present in its issue cycle; an offered instruction holds its fields until accepted.
- R3: `ex_live` is high only when an instruction is offered whose tag equals the execute generation; a non-live instruction is removed when `res_valid` is high and never raises `mispredict` or causes a redirect, whatever `res_taken` and `res_target` are.
- R4: For a live instruction accepted with `res_valid`, `mispredict` is high exactly when the correct successor (`res_target` if `res_taken`, else `ex_pc`+4) differs from `ex_ppc`.
- R5: The execute generation flips in the cycle of a mispredict, so instructions already queued behind it are offered with `ex_live` low.
- R6: A redirect carries the mispredicting instruction's address and its correct successor; when fetch takes it, `upd_pc`/`upd_npc` show that pair and `fetch_pc` holds the successor on the next cycle.
- R7: `upd_valid` is high only in a cycle where fetch issues and a redirect is waiting; in that cycle the fetch generation flips, so instructions fetched from the new address are live.
- R8: When fetch issues with no redirect waiting, `fetch_pc` on the next cycle equals the `pred_npc` of the issue cycle.
- R9: `fetch_fire` is high exactly when the instruction queue has a free slot; otherwise `fetch_pc` holds. The queue head is removed only in cycles with `res_valid` high.
- R10: With the pass-through redirect queue, a mispredict in a cycle where fetch issues is taken by fetch in that same cycle; with the plain queue, `upd_valid` is never high in the cycle of a mispredict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | output | ADDR_W | Address of the instruction being fetched |
| fetch_fire | output | 1 | Fetch issues the instruction at `fetch_pc` this cycle |
| pred_npc | input | ADDR_W | Predicted successor of `fetch_pc`, combinational from predictor |
| imem_inst | input | INST_W | Instruction word at `fetch_pc` |
| ex_valid | output | 1 | An instruction is offered to execute |
| ex_pc | output | ADDR_W | Address of the offered instruction |
| ex_ppc | output | ADDR_W | Predicted successor stored with it |
| ex_inst | output | INST_W | Instruction word stored with it |
| ex_live | output | 1 | Offered instruction is on the current path |
| res_valid | input | 1 | Execute accepts the offered instruction; resolution valid |
| res_taken | input | 1 | Resolved branch direction of a live instruction |
| res_target | input | ADDR_W | Resolved branch target of a live instruction |
| mispredict | output | 1 | Accepted live instruction was mispredicted |
| upd_valid | output | 1 | Predictor training pulse |
| upd_pc | output | ADDR_W | Branch address for training |
| upd_npc | output | ADDR_W | Correct successor for training |

## Verification
The assertions take for granted that `pred_npc`, `imem_inst`, `res_taken` and `res_target` are settled functions of the current `fetch_pc` and `ex_pc` within each cycle, and that `res_valid` does not depend on `ex_live` or on the resolution. The bench obeys this by deriving predictor output, instruction word and branch outcome from fixed address-based functions, and by driving the accept strobe from a counter pattern or a pseudo-random bit that never looks at the design's outputs. Predictor behaviour changes between phases, so runs of correct and wrong predictions both occur and the queue alternates between full and drained.

// File: rtl/fr_pkg.sv
package fr_pkg;

  // Byte distance between sequential instructions.
  localparam int unsigned FR_PC_STEP = 4;

  // Redirect queue variant.
  typedef enum logic {
    FR_Q_PLAIN  = 1'b0,
    FR_Q_BYPASS = 1'b1
  } fr_qkind_e;

endpackage

// File: rtl/fr_fifo.sv
module fr_fifo
  import fr_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2,
  parameter fr_qkind_e   KIND  = FR_Q_PLAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CW-1:0]    count;
  logic             empty;
  logic             pass;
  logic             push;
  logic             pop;

  assign empty    = (count == '0);
  assign in_ready = (count < CW'(DEPTH));

  generate
    if (KIND == FR_Q_BYPASS) begin : g_pass
      // An empty queue hands the incoming entry straight to the reader.
      assign out_valid = !empty || in_valid;
      assign out_data  = empty ? in_data : slots[rd_ptr];
      assign pass      = empty && in_valid && out_ready;
    end else begin : g_plain
      assign out_valid = !empty;
      assign out_data  = slots[rd_ptr];
      assign pass      = 1'b0;
    end
  endgenerate

  assign push = in_valid && in_ready && !pass;
  assign pop  = out_ready && !empty;

  always_ff @(posedge clk) begin
    if (push) begin
      slots[wr_ptr] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      end
      count <= count + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/fr_fetch.sv
module fr_fetch
  import fr_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]  RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_free,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_pc,
  input  logic [ADDR_W-1:0] rd_npc,
  input  logic [ADDR_W-1:0] pred_npc,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              fetch_fire,
  output logic              fetch_gen,
  output logic              rd_take,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_pc,
  output logic [ADDR_W-1:0] upd_npc
);

  logic [ADDR_W-1:0] pc_q;
  logic              gen_q;

  assign fetch_pc   = pc_q;
  assign fetch_gen  = gen_q;
  assign fetch_fire = slot_free;
  assign rd_take    = fetch_fire && rd_valid;

  // Training pulse mirrors the redirect consumed this cycle.
  assign upd_valid = rd_take;
  assign upd_pc    = rd_pc;
  assign upd_npc   = rd_npc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      gen_q <= 1'b0;
    end else if (fetch_fire) begin
      if (rd_valid) begin
        pc_q  <= rd_npc;
        gen_q <= ~gen_q;
      end else begin
        pc_q  <= pred_npc;
      end
    end
  end

endmodule

// File: rtl/fr_exec.sv
module fr_exec
  import fr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_valid,
  input  logic [ADDR_W-1:0] hd_pc,
  input  logic [ADDR_W-1:0] hd_ppc,
  input  logic              hd_gen,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic              ex_live,
  output logic              hd_pop,
  output logic              mispredict,
  output logic [ADDR_W-1:0] fix_pc,
  output logic [ADDR_W-1:0] fix_npc,
  output logic              exec_gen
);

  logic gen_q;
  logic [ADDR_W-1:0] seq_pc;

  assign exec_gen = gen_q;
  assign seq_pc   = hd_pc + ADDR_W'(FR_PC_STEP);
  assign fix_pc   = hd_pc;
  assign fix_npc  = res_taken ? res_target : seq_pc;

  assign ex_live    = hd_valid && (hd_gen == gen_q);
  assign hd_pop     = hd_valid && res_valid;
  assign mispredict = hd_pop && ex_live && (fix_npc != hd_ppc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
    end else if (mispredict) begin
      gen_q <= ~gen_q;
    end
  end

endmodule

// File: rtl/fetch_redirect_unit.sv
module fetch_redirect_unit
  import fr_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       INST_W   = 32,
  parameter int unsigned       IR_DEPTH = 2,
  parameter int unsigned       RQ_DEPTH = 1,
  parameter fr_qkind_e         RQ_KIND  = FR_Q_BYPASS,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              fetch_fire,
  input  logic [ADDR_W-1:0] pred_npc,
  input  logic [INST_W-1:0] imem_inst,
  output logic              ex_valid,
  output logic [ADDR_W-1:0] ex_pc,
  output logic [ADDR_W-1:0] ex_ppc,
  output logic [INST_W-1:0] ex_inst,
  output logic              ex_live,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic              mispredict,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_pc,
  output logic [ADDR_W-1:0] upd_npc
);

  localparam int unsigned IR_W = 2 * ADDR_W + INST_W + 1;
  localparam int unsigned RQ_W = 2 * ADDR_W;

  logic              ir_free;
  logic [IR_W-1:0]   ir_in;
  logic [IR_W-1:0]   ir_out;
  logic              ir_pop;
  logic              fetch_gen;
  logic              exec_gen;
  logic              hd_gen;
  logic              rq_room;
  logic              rq_valid;
  logic              rq_take;
  logic [RQ_W-1:0]   rq_in;
  logic [RQ_W-1:0]   rq_out;
  logic [ADDR_W-1:0] fix_pc;
  logic [ADDR_W-1:0] fix_npc;

  fr_fetch #(
    .ADDR_W  (ADDR_W),
    .RESET_PC(RESET_PC)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_free (ir_free),
    .rd_valid  (rq_valid),
    .rd_pc     (rq_out[RQ_W-1:ADDR_W]),
    .rd_npc    (rq_out[ADDR_W-1:0]),
    .pred_npc  (pred_npc),
    .fetch_pc  (fetch_pc),
    .fetch_fire(fetch_fire),
    .fetch_gen (fetch_gen),
    .rd_take   (rq_take),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_npc   (upd_npc)
  );

  // Instruction stream: {pc, predicted pc, word, generation}.
  assign ir_in = {fetch_pc, pred_npc, imem_inst, fetch_gen};

  fr_fifo #(
    .WIDTH(IR_W),
    .DEPTH(IR_DEPTH),
    .KIND (FR_Q_PLAIN)
  ) u_ir_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (fetch_fire),
    .in_ready (ir_free),
    .in_data  (ir_in),
    .out_valid(ex_valid),
    .out_ready(ir_pop),
    .out_data (ir_out)
  );

  assign ex_pc   = ir_out[IR_W-1 -: ADDR_W];
  assign ex_ppc  = ir_out[IR_W-1-ADDR_W -: ADDR_W];
  assign ex_inst = ir_out[INST_W:1];
  assign hd_gen  = ir_out[0];

  fr_exec #(
    .ADDR_W(ADDR_W)
  ) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .hd_valid  (ex_valid),
    .hd_pc     (ex_pc),
    .hd_ppc    (ex_ppc),
    .hd_gen    (hd_gen),
    .res_valid (res_valid),
    .res_taken (res_taken),
    .res_target(res_target),
    .ex_live   (ex_live),
    .hd_pop    (ir_pop),
    .mispredict(mispredict),
    .fix_pc    (fix_pc),
    .fix_npc   (fix_npc),
    .exec_gen  (exec_gen)
  );

  assign rq_in = {fix_pc, fix_npc};

  // At most one redirect is ever outstanding: after a mispredict every
  // queued instruction is stale until fetch has consumed the redirect.
  fr_fifo #(
    .WIDTH(RQ_W),
    .DEPTH(RQ_DEPTH),
    .KIND (RQ_KIND)
  ) u_redir_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (mispredict),
    .in_ready (rq_room),
    .in_data  (rq_in),
    .out_valid(rq_valid),
    .out_ready(fetch_fire),
    .out_data (rq_out)
  );

endmodule

// File: rtl/fr_chk.sv
module fr_chk
  import fr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter fr_qkind_e   KIND   = FR_Q_BYPASS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              fetch_fire,
  input logic [ADDR_W-1:0] pred_npc,
  input logic              ex_valid,
  input logic              ex_live,
  input logic [ADDR_W-1:0] ex_pc,
  input logic [ADDR_W-1:0] ex_ppc,
  input logic              res_valid,
  input logic              mispredict,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_npc,
  input logic              fetch_gen,
  input logic              exec_gen,
  input logic              rq_room
);

  // R1
  reset_gen_equal_chk: assert property (@(posedge clk) !rst_n |=> fetch_gen == exec_gen);

  // R2
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !res_valid |=> ex_valid && $stable(ex_pc) && $stable(ex_ppc));

  // R3
  stale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_live |-> !mispredict);

  // R4
  miss_needs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> ex_valid && ex_live && res_valid);

  // R5
  exec_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> exec_gen != $past(exec_gen));

  // R5
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mispredict |=> $stable(exec_gen));

  // R6
  redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> fetch_pc == $past(upd_npc));

  // R7
  upd_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> fetch_fire);

  // R7
  fetch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> fetch_gen != $past(fetch_gen));

  // R7
  fetch_hold_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(fetch_gen));

  // R8
  follow_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire && !upd_valid |=> fetch_pc == $past(pred_npc));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_fire |=> $stable(fetch_pc));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> rq_room);

  generate
    if (KIND == FR_Q_BYPASS) begin : g_pass
      // R10
      same_cycle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict && fetch_fire |-> upd_valid);
    end else begin : g_plain
      // R10
      late_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> !upd_valid);
    end
  endgenerate

endmodule

bind fetch_redirect_unit fr_chk #(
  .ADDR_W(ADDR_W),
  .KIND  (RQ_KIND)
) u_fr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_pc  (fetch_pc),
  .fetch_fire(fetch_fire),
  .pred_npc  (pred_npc),
  .ex_valid  (ex_valid),
  .ex_live   (ex_live),
  .ex_pc     (ex_pc),
  .ex_ppc    (ex_ppc),
  .res_valid (res_valid),
  .mispredict(mispredict),
  .upd_valid (upd_valid),
  .upd_npc   (upd_npc),
  .fetch_gen (fetch_gen),
  .exec_gen  (exec_gen),
  .rq_room   (rq_room)
);

// File: tb/fetch_redirect_unit_bench.sv
package frb_pkg;

  function automatic logic [31:0] prog_pred(input logic [1:0] mode, input logic [31:0] pc);
    case (mode)
      2'd0:    return pc + 32'd4;
      2'd1:    return (pc[5:2] == 4'd3) ? 32'h0000_0100 : pc + 32'd4;
      default: return pc[3] ? pc + 32'd12 : pc + 32'd4;
    endcase
  endfunction

  function automatic logic prog_taken(input logic [31:0] pc);
    return (pc[5:2] == 4'd3) || ((pc[5:2] == 4'd9) && pc[6]);
  endfunction

  function automatic logic [31:0] prog_target(input logic [31:0] pc);
    if (pc[5:2] == 4'd3) return pc[8] ? 32'h0000_0040 : 32'h0000_0100;
    return pc + 32'd20;
  endfunction

  function automatic logic [31:0] prog_inst(input logic [31:0] pc);
    return {pc[15:0], ~pc[15:0]};
  endfunction

endpackage

// Behavioural expectation: queues of in-flight items and redirects.
module frb_model
  import frb_pkg::*;
#(
  parameter int IR_DEPTH = 2,
  parameter bit PASS     = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        res_valid,
  input  logic [1:0]  mode,
  output logic [31:0] x_fpc,
  output logic        x_fire,
  output logic        x_exv,
  output logic [31:0] x_expc,
  output logic [31:0] x_exppc,
  output logic [31:0] x_exinst,
  output logic        x_live,
  output logic        x_miss,
  output logic        x_upd,
  output logic [31:0] x_upc,
  output logic [31:0] x_unpc
);

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ppc;
    logic [31:0] inst;
    logic        tag;
  } item_t;

  typedef struct packed {
    logic [31:0] bpc;
    logic [31:0] npc;
  } redir_t;

  item_t       inflight[$];
  redir_t      pending[$];
  logic [31:0] pc;
  logic        fgen;
  logic        egen;
  logic [31:0] good;
  item_t       drop_i;
  redir_t      drop_r;

  always @(negedge clk) begin
    #1;
    x_fpc  = pc;
    x_fire = (inflight.size() < IR_DEPTH);
    x_exv  = (inflight.size() > 0);
    if (x_exv) begin
      x_expc   = inflight[0].pc;
      x_exppc  = inflight[0].ppc;
      x_exinst = inflight[0].inst;
      x_live   = (inflight[0].tag == egen);
    end else begin
      x_expc   = 32'h0;
      x_exppc  = 32'h0;
      x_exinst = 32'h0;
      x_live   = 1'b0;
    end
    good   = prog_taken(x_expc) ? prog_target(x_expc) : x_expc + 32'd4;
    x_miss = x_exv && res_valid && x_live && (good != x_exppc);
    x_upd  = 1'b0;
    x_upc  = 32'h0;
    x_unpc = 32'h0;
    if (x_fire) begin
      if (pending.size() > 0) begin
        x_upd  = 1'b1;
        x_upc  = pending[0].bpc;
        x_unpc = pending[0].npc;
      end else if (PASS && x_miss) begin
        x_upd  = 1'b1;
        x_upc  = x_expc;
        x_unpc = good;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      inflight.delete();
      pending.delete();
      pc   = 32'h0;
      fgen = 1'b0;
      egen = 1'b0;
    end else begin
      if (x_exv && res_valid) drop_i = inflight.pop_front();
      if (x_miss) begin
        egen = ~egen;
        pending.push_back({x_expc, good});
      end
      if (x_fire) inflight.push_back({pc, prog_pred(mode, pc), prog_inst(pc), fgen});
      if (x_upd) begin
        drop_r = pending.pop_front();
        pc     = x_unpc;
        fgen   = ~fgen;
      end else if (x_fire) begin
        pc = prog_pred(mode, pc);
      end
    end
  end

endmodule

module fetch_redirect_unit_bench;
  import fr_pkg::*;
  import frb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PHASE_LEN  = 600;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       running = 1'b0;
  logic       finished = 1'b0;
  int         total = 0;
  int         bad = 0;
  int         pass_same = 0;
  int         plain_same = 0;
  int         stale_seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // DUT A: pass-through redirect queue.
  logic [31:0] fpc_a, pred_a, inst_a, expc_a, exppc_a, exinst_a, tgt_a, upc_a, unpc_a;
  logic        fire_a, exv_a, live_a, tk_a, miss_a, upd_a;
  // DUT B: plain two-entry redirect queue, deeper instruction queue.
  logic [31:0] fpc_b, pred_b, inst_b, expc_b, exppc_b, exinst_b, tgt_b, upc_b, unpc_b;
  logic        fire_b, exv_b, live_b, tk_b, miss_b, upd_b;

  assign pred_a = prog_pred(mode, fpc_a);
  assign inst_a = prog_inst(fpc_a);
  assign tk_a   = prog_taken(expc_a);
  assign tgt_a  = prog_target(expc_a);
  assign pred_b = prog_pred(mode, fpc_b);
  assign inst_b = prog_inst(fpc_b);
  assign tk_b   = prog_taken(expc_b);
  assign tgt_b  = prog_target(expc_b);

  fetch_redirect_unit #(
    .IR_DEPTH(2), .RQ_DEPTH(1), .RQ_KIND(FR_Q_BYPASS)
  ) u_fetch_redirect_unit (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fpc_a), .fetch_fire(fire_a),
    .pred_npc(pred_a), .imem_inst(inst_a), .ex_valid(exv_a), .ex_pc(expc_a),
    .ex_ppc(exppc_a), .ex_inst(exinst_a), .ex_live(live_a), .res_valid(res_valid),
    .res_taken(tk_a), .res_target(tgt_a), .mispredict(miss_a), .upd_valid(upd_a),
    .upd_pc(upc_a), .upd_npc(unpc_a)
  );

  fetch_redirect_unit #(
    .IR_DEPTH(3), .RQ_DEPTH(2), .RQ_KIND(FR_Q_PLAIN)
  ) u_fetch_redirect_unit_q (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fpc_b), .fetch_fire(fire_b),
    .pred_npc(pred_b), .imem_inst(inst_b), .ex_valid(exv_b), .ex_pc(expc_b),
    .ex_ppc(exppc_b), .ex_inst(exinst_b), .ex_live(live_b), .res_valid(res_valid),
    .res_taken(tk_b), .res_target(tgt_b), .mispredict(miss_b), .upd_valid(upd_b),
    .upd_pc(upc_b), .upd_npc(unpc_b)
  );

  logic [31:0] ya_fpc, ya_expc, ya_exppc, ya_exinst, ya_upc, ya_unpc;
  logic        ya_fire, ya_exv, ya_live, ya_miss, ya_upd;
  logic [31:0] yb_fpc, yb_expc, yb_exppc, yb_exinst, yb_upc, yb_unpc;
  logic        yb_fire, yb_exv, yb_live, yb_miss, yb_upd;

  frb_model #(.IR_DEPTH(2), .PASS(1'b1)) u_model_a (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .mode(mode),
    .x_fpc(ya_fpc), .x_fire(ya_fire), .x_exv(ya_exv), .x_expc(ya_expc),
    .x_exppc(ya_exppc), .x_exinst(ya_exinst), .x_live(ya_live), .x_miss(ya_miss),
    .x_upd(ya_upd), .x_upc(ya_upc), .x_unpc(ya_unpc)
  );

  frb_model #(.IR_DEPTH(3), .PASS(1'b0)) u_model_b (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .mode(mode),
    .x_fpc(yb_fpc), .x_fire(yb_fire), .x_exv(yb_exv), .x_expc(yb_expc),
    .x_exppc(yb_exppc), .x_exinst(yb_exinst), .x_live(yb_live), .x_miss(yb_miss),
    .x_upd(yb_upd), .x_upc(yb_upc), .x_unpc(yb_unpc)
  );

  task automatic chk(input string what, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && running) begin
      chk("A fetch_pc", "R8", fpc_a, ya_fpc);
      chk("A fetch_fire", "R9", 32'(fire_a), 32'(ya_fire));
      chk("A ex_valid", "R2", 32'(exv_a), 32'(ya_exv));
      if (ya_exv) begin
        chk("A ex_pc", "R2", expc_a, ya_expc);
        chk("A ex_ppc", "R2", exppc_a, ya_exppc);
        chk("A ex_inst", "R2", exinst_a, ya_exinst);
      end
      chk("A ex_live (R5)", "R3", 32'(live_a), 32'(ya_live));
      chk("A mispredict", "R4", 32'(miss_a), 32'(ya_miss));
      chk("A upd_valid", "R7", 32'(upd_a), 32'(ya_upd));
      if (ya_upd) begin
        chk("A upd_pc", "R6", upc_a, ya_upc);
        chk("A upd_npc", "R6", unpc_a, ya_unpc);
      end
      chk("B fetch_pc", "R8", fpc_b, yb_fpc);
      chk("B fetch_fire", "R9", 32'(fire_b), 32'(yb_fire));
      chk("B ex_valid", "R2", 32'(exv_b), 32'(yb_exv));
      if (yb_exv) begin
        chk("B ex_pc", "R2", expc_b, yb_expc);
        chk("B ex_ppc", "R2", exppc_b, yb_exppc);
        chk("B ex_inst", "R2", exinst_b, yb_exinst);
      end
      chk("B ex_live (R5)", "R3", 32'(live_b), 32'(yb_live));
      chk("B mispredict", "R4", 32'(miss_b), 32'(yb_miss));
      chk("B upd_valid", "R7", 32'(upd_b), 32'(yb_upd));
      if (yb_upd) begin
        chk("B upd_pc", "R6", upc_b, yb_upc);
        chk("B upd_npc", "R6", unpc_b, yb_unpc);
      end
      if (miss_a && upd_a) pass_same++;
      if (miss_b && upd_b) plain_same++;
      if (exv_a && !live_a && res_valid) stale_seen++;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    // R1: reset state at the ports.
    chk("A reset fetch_pc", "R1", fpc_a, 32'h0);
    chk("A reset ex_valid", "R1", 32'(exv_a), 32'h0);
    chk("A reset upd_valid", "R1", 32'(upd_a), 32'h0);
    chk("A reset mispredict", "R1", 32'(miss_a), 32'h0);
    chk("B reset fetch_pc", "R1", fpc_b, 32'h0);
    chk("B reset ex_valid", "R1", 32'(exv_b), 32'h0);
    chk("B reset ex_live", "R1", 32'(live_b), 32'h0);
    rst_n   = 1'b1;
    running = 1'b1;
    for (int cyc = 0; cyc < 4 * PHASE_LEN; cyc++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (cyc / PHASE_LEN)
        0: begin mode = 2'd0; res_valid = 1'b1; end
        1: begin mode = 2'd1; res_valid = lfsr[0]; end
        2: begin mode = 2'd2; res_valid = ((cyc % 8) < 2); end
        default: begin mode = 2'd1; res_valid = 1'b1; end
      endcase
    end
    @(negedge clk);
    #3;
    running = 1'b0;
    // R10: same-cycle take only with the pass-through queue.
    chk("A same-cycle redirect seen", "R10", 32'(pass_same > 0), 32'h1);
    chk("B same-cycle redirect count", "R10", 32'(plain_same), 32'h0);
    // R3: stale instructions were actually dropped during the run.
    chk("A stale drops seen", "R3", 32'(stale_seen > 0), 32'h1);
    finished = 1'b1;
    finish_run();
  end

endmodule